// File: doc/BRIEF.md
# Byte-Bus Four-Channel Converter Code Loader

This block sits between an 8-bit processor write bus and four 12-bit converter channels. Each channel has two storage stages. The first stage is assembled one byte at a time. The second stage is the code presented to the converter. A processor fills the first stage of every channel with two byte writes per channel. The codes are right-justified: the low byte holds code bits 7..0 and the lower nibble of the second byte holds bits 11..8. A single broadcast write then copies all first stages into the output codes in the same clock, so every channel changes at once.

Addresses are decoded against a base value held in the high address bits. Eight adjacent addresses reach the eight first-stage byte slots. A further address bit requests the broadcast update. In the alternative mode, selected by a pin, there is no update address. Instead, the write of the last channel's low byte also performs the broadcast, and the byte just written is part of the new code.

The write strobe is a plain level control sampled on the clock. A pulse of any length produces exactly one action, taken on its first clocked cycle. There is no back-pressure: every matching pulse is accepted.

Top module: `dacld_top`

## Requirements
- R1: While reset is asserted and after it is released, every output code is 0x800. Every first-stage slot also holds 0x800, so an update issued before any load keeps all outputs at 0x800.
- R2: A write with address bit 0 clear stores the data byte as code bits 7..0 of the addressed channel's first stage. A write with bit 0 set stores data bits 3..0 as code bits 11..8. Data bits 7..4 of a high-nibble write are ignored.
- R3: Address bits 2..1 select the channel, 0 to 3. Channel k occupies output bits 12k+11..12k.
- R4: A first-stage write does not change any output code. The one exception is the merging write of R7.
- R5: With the mode pin low, a write with address bit 3 set copies every channel's first-stage value, as it stood before that cycle, into its output code. Address bits 2..0 and the data are ignored on that write.
- R6: A write whose address bits 15..4 differ from the configured base changes nothing.
- R7: With the mode pin high, a write to channel 3's low byte (bits 3..0 = 0110) stores the byte and updates every output code in the same cycle. The new channel 3 code includes that byte.
- R8: With the mode pin high, a write with address bit 3 set is ignored entirely.
- R9: A strobe held high for several cycles acts once, with the address and data of its first cycle.
- R10: The mode pin is sampled only on clock edges where the strobe is low. A change of the mode pin during a pulse does not affect that pulse.
- R11: An accepted write takes effect on the clock edge where the strobe is first seen high. The outputs show the result right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Write address |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, active high |
| last_trig_mode | input | 1 | 1: the last channel's low-byte write triggers the update; 0: the separate update address does |
| dac_codes | output | 48 | Four 12-bit output codes, channel 0 in the low bits |

## Verification
A fault in the first stage stays hidden until the next broadcast. So a wrong byte slot, a lost upper-nibble mask or a stale first-stage value shows at the ports only one update later, as a wrong code on one channel. A fault in the update or mode path shows at once: outputs change after a plain load, stay frozen after a broadcast, or update from the wrong address in the other mode. A faulty pulse detector reveals itself when a long strobe carries changing data and the later byte reaches the output.

// File: rtl/dacld_pkg.sv
package dacld_pkg;
  localparam int CODE_W = 12;
  localparam int LO_W   = 8;
  localparam int HI_W   = CODE_W - LO_W;
  localparam logic [CODE_W-1:0] MID_CODE = 12'h800;

  typedef struct packed {
    logic [HI_W-1:0] hi;
    logic [LO_W-1:0] lo;
  } rank_t;

  function automatic rank_t rank_mid();
    rank_t r;
    r = rank_t'(MID_CODE);
    return r;
  endfunction
endpackage

// File: rtl/dacld_strobe.sv
module dacld_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_in,
  input  logic mode_in,
  output logic fire,
  output logic mode_q
);
  logic wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      wr_q <= wr_in;
      if (!wr_in) mode_q <= mode_in;
    end
  end

  assign fire = wr_in & ~wr_q;
endmodule

// File: rtl/dacld_decode.sv
module dacld_decode #(
  parameter int ADDR_W = 16,
  parameter int NCH    = 4,
  parameter int CH_W   = $clog2(NCH),
  parameter int BASE_W = ADDR_W - CH_W - 2,
  parameter logic [BASE_W-1:0] BASE = '0
) (
  input  logic              fire,
  input  logic              mode_q,
  input  logic [ADDR_W-1:0] addr,
  output logic [NCH-1:0]    ld_sel,
  output logic              ld_hi,
  output logic              upd_all
);
  localparam int UPD_BIT = CH_W + 1;

  logic            hit;
  logic            upd_bit;
  logic [CH_W-1:0] ch;
  logic            load;

  assign hit     = (addr[ADDR_W-1:UPD_BIT+1] == BASE);
  assign upd_bit = addr[UPD_BIT];
  assign ch      = addr[CH_W:1];
  assign ld_hi   = addr[0];
  assign load    = fire & hit & ~upd_bit;

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign ld_sel[i] = load & (ch == CH_W'(i));
  end

  always_comb begin
    if (mode_q) upd_all = load & (ch == CH_W'(NCH - 1)) & ~ld_hi;
    else        upd_all = fire & hit & upd_bit;
  end
endmodule

// File: rtl/dacld_chan.sv
module dacld_chan
  import dacld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic              ld_hi,
  input  logic [LO_W-1:0]   wdata,
  input  logic              upd,
  output logic [CODE_W-1:0] code
);
  rank_t fr, fr_nxt;

  always_comb begin
    fr_nxt = fr;
    if (ld_en) begin
      if (ld_hi) fr_nxt.hi = wdata[HI_W-1:0];
      else       fr_nxt.lo = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr   <= rank_mid();
      code <= MID_CODE;
    end else begin
      fr <= fr_nxt;
      if (upd) code <= CODE_W'(fr_nxt);
    end
  end
endmodule

// File: rtl/dacld_top.sv
module dacld_top
  import dacld_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NCH    = 4,
  parameter logic [ADDR_W-$clog2(NCH)-3:0] BASE = 12'h0C3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [LO_W-1:0]       bus_wdata,
  input  logic                  bus_wr,
  input  logic                  last_trig_mode,
  output logic [NCH*CODE_W-1:0] dac_codes
);
  localparam int CH_W   = $clog2(NCH);
  localparam int BASE_W = ADDR_W - CH_W - 2;

  logic           fire;
  logic           mode_q;
  logic [NCH-1:0] ld_sel;
  logic           ld_hi;
  logic           upd_all;

  dacld_strobe u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_in   (bus_wr),
    .mode_in (last_trig_mode),
    .fire    (fire),
    .mode_q  (mode_q)
  );

  dacld_decode #(
    .ADDR_W (ADDR_W),
    .NCH    (NCH),
    .CH_W   (CH_W),
    .BASE_W (BASE_W),
    .BASE   (BASE)
  ) u_dec (
    .fire    (fire),
    .mode_q  (mode_q),
    .addr    (bus_addr),
    .ld_sel  (ld_sel),
    .ld_hi   (ld_hi),
    .upd_all (upd_all)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dacld_chan u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_en (ld_sel[i]),
      .ld_hi (ld_hi),
      .wdata (bus_wdata),
      .upd   (upd_all),
      .code  (dac_codes[i*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/dacld_checker.sv
module dacld_checker #(
  parameter int ADDR_W = 16,
  parameter int NCH    = 4,
  parameter logic [ADDR_W-$clog2(NCH)-3:0] BASE = 12'h0C3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic [NCH*12-1:0]   dac_codes
);
  localparam int UPD_BIT = $clog2(NCH) + 1;
  localparam logic [NCH*12-1:0] ALL_MID = {NCH{12'h800}};

  // R1: outputs sit at mid-scale through reset
  p_reset_mid_r1: assert property (@(posedge clk)
    !rst_n |=> (dac_codes == ALL_MID));

  // R4: no strobe, no change
  p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(dac_codes));

  // R4: a high-nibble load never moves an output, in either mode
  p_nibble_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !$past(bus_wr) && !bus_addr[UPD_BIT] && bus_addr[0]) |=> $stable(dac_codes));

  // R6: a base mismatch is inert
  p_base_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[ADDR_W-1:UPD_BIT+1] != BASE) |=> $stable(dac_codes));

  // R9: only the first cycle of a pulse acts
  p_held_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && $past(bus_wr)) |=> $stable(dac_codes));
endmodule

bind dacld_top dacld_checker #(
  .ADDR_W (ADDR_W),
  .NCH    (NCH),
  .BASE   (BASE)
) u_dacld_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .dac_codes (dac_codes)
);

// File: tb/dacld_top_test.sv
module dacld_top_test;
  localparam logic [11:0] BASE = 12'h0C3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        last_trig_mode = 1'b0;
  logic [47:0] dac_codes;

  int tests = 0;
  int fails = 0;

  logic [7:0]  m_lo  [4];
  logic [3:0]  m_hi  [4];
  logic [11:0] m_out [4];
  logic        m_mode;

  always #4 clk = ~clk;

  dacld_top uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_wr         (bus_wr),
    .last_trig_mode (last_trig_mode),
    .dac_codes      (dac_codes)
  );

  function automatic logic [47:0] exp_vec();
    return {m_out[3], m_out[2], m_out[1], m_out[0]};
  endfunction

  function automatic logic [15:0] mk_addr(input logic upd, input logic [1:0] ch, input logic hi);
    return {BASE, upd, ch, hi};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_lo[i] = 8'h00; m_hi[i] = 4'h8; m_out[i] = 12'h800;
    end
    m_mode = 1'b0;
  endtask

  task automatic model_apply(input logic [15:0] a, input logic [7:0] d);
    logic [1:0] ch;
    ch = a[2:1];
    if (a[15:4] != BASE) return;
    if (!a[3]) begin
      if (a[0]) m_hi[ch] = d[3:0]; else m_lo[ch] = d;
      if (m_mode && ch == 2'd3 && !a[0])
        for (int i = 0; i < 4; i++) m_out[i] = {m_hi[i], m_lo[i]};
    end else if (!m_mode) begin
      for (int i = 0; i < 4; i++) m_out[i] = {m_hi[i], m_lo[i]};
    end
  endtask

  task automatic check(input string tag);
    tests++;
    if (dac_codes !== exp_vec()) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, dac_codes, exp_vec());
    end
  endtask

  // one pulse of 'len' cycles; mode pin takes new_mode with the pulse (R10)
  task automatic write(input logic [15:0] a, input logic [7:0] d, input logic new_mode,
                       input int len, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; last_trig_mode = new_mode;
    model_apply(a, d);
    for (int k = 1; k < len; k++) begin
      @(negedge clk);
      bus_wdata = ~bus_wdata;
      bus_addr[0] = ~bus_addr[0];
    end
    @(negedge clk);
    bus_wr = 1'b0;
    check(tag);
    m_mode = new_mode;
  endtask

  initial begin
    #(8 * 200000);
    fails++; tests++;
    $display("FAIL watchdog: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");
    write(mk_addr(1'b1, 2'd2, 1'b1), 8'h5A, 1'b0, 1, "R1 first stage mid");

    // R2/R3/R4: load distinct codes, outputs must stay put
    for (int c = 0; c < 4; c++) begin
      write(mk_addr(1'b0, 2'(c), 1'b0), 8'h10 + 8'(c), 1'b0, 1, "R4 low load");
      write(mk_addr(1'b0, 2'(c), 1'b1), 8'hF0 | 8'(c + 1), 1'b0, 1, "R2 nibble load");
    end
    write(mk_addr(1'b1, 2'd0, 1'b0), 8'hFF, 1'b0, 1, "R5 R3 R2 broadcast");
    write(16'h1238, 8'h00, 1'b0, 1, "R6 miss update");
    write(16'h0000, 8'h77, 1'b0, 1, "R6 miss load");
    write(mk_addr(1'b1, 2'd0, 1'b0), 8'h00, 1'b0, 1, "R6 no first-stage change");

    // R9: long pulse, later cycles flip byte slot and data
    write(mk_addr(1'b0, 2'd1, 1'b0), 8'hA7, 1'b0, 3, "R9 held load");
    write(mk_addr(1'b1, 2'd3, 1'b1), 8'h00, 1'b0, 3, "R9 held update");

    // R10: mode raised with the pulse is not used by it
    write(mk_addr(1'b0, 2'd3, 1'b0), 8'h3C, 1'b1, 1, "R10 mode during pulse");
    // R7: now in mode 1, last low byte merges and updates
    write(mk_addr(1'b0, 2'd0, 1'b1), 8'h0E, 1'b1, 1, "R7 prep");
    write(mk_addr(1'b0, 2'd3, 1'b1), 8'h09, 1'b1, 1, "R7 last nibble no update");
    write(mk_addr(1'b0, 2'd3, 1'b0), 8'hC5, 1'b1, 1, "R7 merge update");
    write(mk_addr(1'b0, 2'd2, 1'b0), 8'h44, 1'b1, 1, "R8 prep");
    write(mk_addr(1'b1, 2'd3, 1'b0), 8'h99, 1'b1, 1, "R8 update bit ignored");
    write(mk_addr(1'b0, 2'd3, 1'b0), 8'h11, 1'b0, 1, "R8 R7 flush");

    // random mix, R11 timing checked on every op
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      int r;
      r = int'($urandom_range(0, 99));
      a = mk_addr(r < 20, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      if (r >= 90) a[15:4] = BASE ^ 12'($urandom_range(1, 4095));
      if (r < 20) a[2:0] = 3'($urandom_range(0, 7));
      write(a, 8'($urandom), ($urandom_range(0, 9) == 0) ? ~m_mode : m_mode,
            int'($urandom_range(1, 3)), "R11 random");
    end

    // R1: reset mid-run restores mid-scale
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    last_trig_mode = 1'b0;
    @(negedge clk);
    check("R1 re-reset");
    rst_n = 1'b1;
    write(mk_addr(1'b1, 2'd0, 1'b0), 8'h00, 1'b0, 1, "R1 re-reset first stage");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule